// File: doc/BRIEF.md
# SPI Flash Interposer Opcode Filter

This block sits in series on the single-lane SPI link (mode 0) between an upstream host and the NOR flash behind it. It decodes the first byte that follows each chip-select assertion and looks it up in a programmable policy table. The table selects one of three treatments. A locally answered command is serviced by the block, and the flash never sees it. A pass-through command is replayed to the flash one byte behind the host. A captured command is recorded for a firmware agent, and the flash does not see it either.

Pass-through traffic is routed to one half of a flash that is twice the size of the host's view. The block overwrites one address bit (parameter `HALF_BIT`, default 23) with an active-half select, so the host only sees the half that is currently live. Captured transactions keep the opcode, a 3-byte address and up to `DEPTH` data bytes. When capture completes, a pending flag is raised for firmware, which reads the record back through a side port and then clears the flag.

All upstream pins are assumed to be already sampled into the `clk` domain, and `up_sclk` runs at no more than one eighth of `clk`. The downstream clock is a registered and gated copy of `up_sclk`.

Top module: `ifp_top`

## Requirements
- R1: `dn_cs_n` stays high from the upstream chip-select assertion until all 8 opcode bits have been received. It goes low only for pass-through opcodes, and `dn_sclk` pulses only while `dn_cs_n` is low.
- R2: Locally answered opcodes return data MSB first, starting with the byte after the opcode. Opcode 0x05 returns a status byte. Opcode 0x9F returns the three `DEV_ID` bytes, most significant first, and repeats them. Any other local opcode returns 0x00.
- R3: For pass-through, `dn_mosi` carries the upstream bit stream delayed by exactly 8 `up_sclk` cycles, so byte k reaches the flash while the host sends byte k+1. While `dn_cs_n` is low, `up_miso` mirrors `dn_miso`.
- R4: In pass-through, upstream address bit `HALF_BIT` (address bytes follow the opcode, MSB first) is replaced downstream by the active-half value. All other bits are relayed unchanged.
- R5: A half-select write takes effect only while the upstream chip select is deasserted. A write made mid-transaction applies from the next transaction onward.
- R6: A capture-policy opcode produces no downstream activity. The block records the opcode in `cap_op`, the next three bytes in `cap_addr` (first byte in bits 23:16), and the following bytes in the buffer with their count in `cap_len`. `cap_pending` rises once the upstream chip select deasserts and stays high until `cap_clear`.
- R7: Data bytes beyond `DEPTH` in one captured transaction are dropped, and `cap_len` saturates at `DEPTH`.
- R8: While `cap_pending` is high, a further capture-policy transaction changes none of the recorded fields.
- R9: The status byte from opcode 0x05 has bit 0 equal to `cap_pending`, and its other bits are 0.
- R10: Writing `pol_val` for `pol_op` changes how that opcode is treated from then on. The encoding is 0 = local, 1 = pass-through, 2 = capture, 3 = local. After reset, 0x03 and 0x0B are pass-through; 0x02, 0x06, 0x20, 0xD8 and 0xC7 are captured; every other opcode is local.
- R11: After reset, `dn_cs_n` is 1, `dn_sclk` is 0, `up_miso` is 0 and `cap_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_cs_n | input | 1 | Upstream chip select, active low |
| up_sclk | input | 1 | Upstream serial clock |
| up_mosi | input | 1 | Upstream data from host |
| up_miso | output | 1 | Upstream data to host |
| dn_cs_n | output | 1 | Flash chip select, active low |
| dn_sclk | output | 1 | Flash serial clock |
| dn_mosi | output | 1 | Data to flash |
| dn_miso | input | 1 | Data from flash |
| half_we | input | 1 | Half-select write strobe |
| half_val | input | 1 | Requested half (0 lower, 1 upper) |
| pol_we | input | 1 | Policy-table write strobe |
| pol_op | input | 8 | Opcode whose policy is written |
| pol_val | input | 2 | Policy code to write |
| cap_pending | output | 1 | Captured transaction awaits firmware |
| cap_clear | input | 1 | Firmware release of the capture record |
| cap_op | output | 8 | Captured opcode |
| cap_addr | output | 24 | Captured address |
| cap_len | output | LENW | Number of captured data bytes |
| cap_rd_idx | input | IDXW | Capture buffer read index |
| cap_rd_data | output | 8 | Capture buffer byte at `cap_rd_idx` |

## Verification
The hardest conditions to reach are the ones that only show up in the middle of a transaction. One is a half-select write landing between the opcode and the address. Another is a capture arriving while an earlier record is still pending. A third is a data phase that runs past the buffer depth. The bench splits the host task into begin, per-byte and end steps so it can issue a half-select write after the opcode byte. It also chains a write-enable capture, a status read and a second program command without clearing in between. Finally, it streams 260 data bytes in a single transaction and checks the saturated length and the last stored byte.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  typedef enum logic [1:0] {
    POL_LOCAL = 2'b00,
    POL_PASS  = 2'b01,
    POL_CAPT  = 2'b10,
    POL_RSVD  = 2'b11
  } pol_e;

  function automatic pol_e pol_default(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B:                      return POL_PASS;
      8'h02, 8'h06, 8'h20, 8'hD8, 8'hC7: return POL_CAPT;
      default:                           return POL_LOCAL;
    endcase
  endfunction
endpackage

// File: rtl/ifp_spi_rx.sv
module ifp_spi_rx #(
  parameter int BYW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           mosi,
  output logic           rise,
  output logic           fall,
  output logic           cs_end,
  output logic           byte_done,
  output logic [2:0]     bit_ix,
  output logic [BYW-1:0] byte_ix,
  output logic [7:0]     byte_val
);
  logic           sclk_q, csn_q;
  logic [6:0]     sr_q, sr_n;
  logic [2:0]     bit_n;
  logic [BYW-1:0] byte_n;

  assign rise      = !cs_n && sclk && !sclk_q;
  assign fall      = !cs_n && !sclk && sclk_q;
  assign cs_end    = cs_n && !csn_q;
  assign byte_done = rise && (bit_ix == 3'd7);
  assign byte_val  = {sr_q, mosi};

  always_comb begin
    sr_n   = sr_q;
    bit_n  = bit_ix;
    byte_n = byte_ix;
    if (cs_n) begin
      sr_n   = '0;
      bit_n  = '0;
      byte_n = '0;
    end else if (rise) begin
      sr_n  = {sr_q[5:0], mosi};
      bit_n = bit_ix + 3'd1;
      if (bit_ix == 3'd7 && byte_ix != '1) byte_n = byte_ix + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      sr_q    <= '0;
      bit_ix  <= '0;
      byte_ix <= '0;
    end else begin
      sclk_q  <= sclk;
      csn_q   <= cs_n;
      sr_q    <= sr_n;
      bit_ix  <= bit_n;
      byte_ix <= byte_n;
    end
  end
endmodule

// File: rtl/ifp_pol_tbl.sv
module ifp_pol_tbl
  import ifp_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [OPW-1:0] wop,
  input  logic [1:0]     wval,
  input  logic [OPW-1:0] rop,
  output pol_e           rpol
);
  localparam int NOPS = 1 << OPW;
  pol_e tbl [NOPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOPS; i++) tbl[i] <= pol_default(8'(i));
    end else if (we) begin
      tbl[wop] <= pol_e'(wval);
    end
  end

  assign rpol = tbl[rop];
endmodule

// File: rtl/ifp_capt.sv
module ifp_capt #(
  parameter int DEPTH = 256,
  parameter int BYW   = 9,
  localparam int IDXW = $clog2(DEPTH),
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            byte_done,
  input  logic [BYW-1:0]  byte_ix,
  input  logic [7:0]      byte_val,
  input  logic            cs_end,
  input  logic            clear,
  input  logic [IDXW-1:0] rd_idx,
  output logic            pending,
  output logic            active,
  output logic [7:0]      op,
  output logic [23:0]     addr,
  output logic [LENW-1:0] len,
  output logic [7:0]      rd_data
);
  logic [7:0]  mem [DEPTH];
  logic        act_n, pend_n;
  logic [7:0]  op_n;
  logic [23:0] addr_n;
  logic [LENW-1:0] len_n;
  logic        wr_en;

  assign wr_en = active && byte_done && (byte_ix >= BYW'(4)) && (len < LENW'(DEPTH));

  always_comb begin
    act_n  = active;
    pend_n = pending;
    op_n   = op;
    addr_n = addr;
    len_n  = len;
    if (start) begin
      act_n = 1'b1;
      op_n  = byte_val;
      len_n = '0;
    end
    if (active && byte_done && byte_ix >= BYW'(1) && byte_ix <= BYW'(3))
      addr_n = {addr[15:0], byte_val};
    if (wr_en) len_n = len + 1'b1;
    if (clear) pend_n = 1'b0;
    if (cs_end) begin
      act_n = 1'b0;
      if (active) pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
      op      <= '0;
      addr    <= '0;
      len     <= '0;
    end else begin
      active  <= act_n;
      pending <= pend_n;
      op      <= op_n;
      addr    <= addr_n;
      len     <= len_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[len[IDXW-1:0]] <= byte_val;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ifp_top.sv
module ifp_top
  import ifp_pkg::*;
#(
  parameter int          DEPTH     = 256,
  parameter int          HALF_BIT  = 23,
  parameter logic [7:0]  STATUS_OP = 8'h05,
  parameter logic [7:0]  ID_OP     = 8'h9F,
  parameter logic [23:0] DEV_ID    = 24'hC22018,
  localparam int IDXW = $clog2(DEPTH),
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_cs_n,
  input  logic            up_sclk,
  input  logic            up_mosi,
  output logic            up_miso,
  output logic            dn_cs_n,
  output logic            dn_sclk,
  output logic            dn_mosi,
  input  logic            dn_miso,
  input  logic            half_we,
  input  logic            half_val,
  input  logic            pol_we,
  input  logic [7:0]      pol_op,
  input  logic [1:0]      pol_val,
  output logic            cap_pending,
  input  logic            cap_clear,
  output logic [7:0]      cap_op,
  output logic [23:0]     cap_addr,
  output logic [LENW-1:0] cap_len,
  input  logic [IDXW-1:0] cap_rd_idx,
  output logic [7:0]      cap_rd_data
);
  localparam int BYW     = $clog2(DEPTH + 8);
  localparam int SUB_CNT = 16 + (23 - HALF_BIT);
  localparam logic [BYW-1:0] SUB_BYTE = BYW'(SUB_CNT / 8);
  localparam logic [2:0]     SUB_BIT  = 3'(SUB_CNT % 8);

  logic rst_m, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s_n, rst_m} <= 2'b00;
    else        {rst_s_n, rst_m} <= {rst_m, 1'b1};
  end

  logic rise, fall, cs_end, byte_done;
  logic [2:0] bit_ix;
  logic [BYW-1:0] byte_ix;
  logic [7:0] byte_val;
  pol_e pol;
  logic cap_act, op_done;

  ifp_spi_rx #(.BYW(BYW)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .cs_n(up_cs_n), .sclk(up_sclk), .mosi(up_mosi),
    .rise(rise), .fall(fall), .cs_end(cs_end), .byte_done(byte_done),
    .bit_ix(bit_ix), .byte_ix(byte_ix), .byte_val(byte_val));

  ifp_pol_tbl #(.OPW(8)) u_tbl (
    .clk(clk), .rst_n(rst_s_n), .we(pol_we), .wop(pol_op), .wval(pol_val),
    .rop(byte_val), .rpol(pol));

  assign op_done = byte_done && (byte_ix == '0);

  ifp_capt #(.DEPTH(DEPTH), .BYW(BYW)) u_cap (
    .clk(clk), .rst_n(rst_s_n),
    .start(op_done && pol == POL_CAPT && !cap_pending),
    .byte_done(byte_done), .byte_ix(byte_ix), .byte_val(byte_val),
    .cs_end(cs_end), .clear(cap_clear), .rd_idx(cap_rd_idx),
    .pending(cap_pending), .active(cap_act), .op(cap_op), .addr(cap_addr),
    .len(cap_len), .rd_data(cap_rd_data));

  // Routing state
  logic [7:0] op_q, op_n, dl_q, dl_n;
  logic [6:0] tx_q, tx_n;
  logic [1:0] id_q, id_n;
  logic pass_q, pass_n, loc_q, loc_n, en_q, en_n;
  logic sck_q, sck_n, dmo_q, dmo_n, mi_q, mi_n;
  logic half_req, half_act;
  logic [7:0] resp;

  always_comb begin
    if (op_q == STATUS_OP) resp = {7'b0, cap_pending};
    else if (op_q == ID_OP) begin
      case (id_q)
        2'd0:    resp = DEV_ID[23:16];
        2'd1:    resp = DEV_ID[15:8];
        default: resp = DEV_ID[7:0];
      endcase
    end else resp = 8'h00;
  end

  always_comb begin
    op_n = op_q;  dl_n = dl_q;  tx_n = tx_q;  id_n = id_q;
    pass_n = pass_q;  loc_n = loc_q;  en_n = en_q;
    dmo_n = dmo_q;  mi_n = mi_q;
    if (up_cs_n) begin
      dl_n = '0;  pass_n = 1'b0;  loc_n = 1'b0;  en_n = 1'b0;
      dmo_n = 1'b0;  mi_n = 1'b0;
    end else begin
      if (rise) dl_n = {dl_q[6:0], up_mosi};
      if (op_done) begin
        op_n   = byte_val;
        pass_n = (pol == POL_PASS);
        loc_n  = (pol == POL_LOCAL) || (pol == POL_RSVD);
        id_n   = 2'd0;
      end
      if (fall && pass_q) begin
        en_n  = 1'b1;
        dmo_n = (byte_ix == SUB_BYTE && bit_ix == SUB_BIT) ? half_act : dl_q[7];
      end
      if (fall && loc_q) begin
        if (bit_ix == 3'd0) begin
          mi_n = resp[7];
          tx_n = resp[6:0];
          id_n = (id_q == 2'd2) ? 2'd0 : id_q + 2'd1;
        end else begin
          mi_n = tx_q[6];
          tx_n = {tx_q[5:0], 1'b0};
        end
      end
    end
    sck_n = up_sclk && en_q && pass_q && !up_cs_n;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      op_q <= '0;  dl_q <= '0;  tx_q <= '0;  id_q <= '0;
      pass_q <= 1'b0;  loc_q <= 1'b0;  en_q <= 1'b0;
      sck_q <= 1'b0;  dmo_q <= 1'b0;  mi_q <= 1'b0;
      half_req <= 1'b0;  half_act <= 1'b0;
    end else begin
      op_q <= op_n;  dl_q <= dl_n;  tx_q <= tx_n;  id_q <= id_n;
      pass_q <= pass_n;  loc_q <= loc_n;  en_q <= en_n;
      sck_q <= sck_n;  dmo_q <= dmo_n;  mi_q <= mi_n;
      if (half_we) half_req <= half_val;
      if (up_cs_n) half_act <= half_req;
    end
  end

  assign dn_cs_n = !pass_q;
  assign dn_sclk = sck_q;
  assign dn_mosi = dmo_q;
  assign up_miso = pass_q ? dn_miso : mi_q;
endmodule

// File: rtl/ifp_chk.sv
module ifp_chk #(
  parameter int DEPTH = 256,
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            up_cs_n,
  input logic            dn_cs_n,
  input logic            dn_sclk,
  input logic            half_act,
  input logic            cap_pending,
  input logic            cap_clear,
  input logic            cap_act,
  input logic [LENW-1:0] cap_len
);
  // R1: flash selected only inside an upstream transaction
  p_dn_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_cs_n |-> !$past(up_cs_n));
  // R1: flash clock only while flash is selected
  p_sclk_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sclk |-> !dn_cs_n);
  // R5: active half frozen during a transaction
  p_half_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_cs_n && !$past(up_cs_n)) |-> $stable(half_act));
  // R6: pending holds until firmware clears it
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pending && !cap_clear) |=> cap_pending);
  // R6: a capture never reaches the flash
  p_capt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_act |-> dn_cs_n);
  // R7: length bounded by buffer depth
  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_len <= LENW'(DEPTH));
  // R8: no new capture starts while one is pending
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pending |=> !$rose(cap_act));
endmodule

bind ifp_top ifp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .up_cs_n(up_cs_n), .dn_cs_n(dn_cs_n),
  .dn_sclk(dn_sclk), .half_act(half_act), .cap_pending(cap_pending),
  .cap_clear(cap_clear), .cap_act(cap_act), .cap_len(cap_len));

// File: tb/ifp_top_tb.sv
module ifp_top_tb;
  localparam int H = 4;
  localparam logic [7:0] FDATA = 8'hA5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, up_cs_n, up_sclk, up_mosi, up_miso;
  logic dn_cs_n, dn_sclk, dn_mosi, dn_miso;
  logic half_we, half_val, pol_we, cap_clear, cap_pending;
  logic [7:0] pol_op, cap_op, cap_rd_data;
  logic [1:0] pol_val;
  logic [23:0] cap_addr;
  logic [8:0] cap_len;
  logic [7:0] cap_rd_idx;

  ifp_top u_dut (
    .clk(clk), .rst_n(rst_n), .up_cs_n(up_cs_n), .up_sclk(up_sclk),
    .up_mosi(up_mosi), .up_miso(up_miso), .dn_cs_n(dn_cs_n), .dn_sclk(dn_sclk),
    .dn_mosi(dn_mosi), .dn_miso(dn_miso), .half_we(half_we), .half_val(half_val),
    .pol_we(pol_we), .pol_op(pol_op), .pol_val(pol_val), .cap_pending(cap_pending),
    .cap_clear(cap_clear), .cap_op(cap_op), .cap_addr(cap_addr), .cap_len(cap_len),
    .cap_rd_idx(cap_rd_idx), .cap_rd_data(cap_rd_data));

  int n_chk = 0, n_fail = 0;
  int dn_cnt;
  logic dn_clr;
  logic [7:0] dn_bytes [8];
  logic [7:0] txb [300];
  logic [7:0] rxb [8];

  // flash side monitor and simple responder
  always @(posedge dn_sclk or posedge dn_clr) begin
    if (dn_clr) begin
      dn_cnt = 0;
      for (int i = 0; i < 8; i++) dn_bytes[i] = 8'h00;
    end else begin
      if (dn_cnt < 64) dn_bytes[dn_cnt / 8][7 - (dn_cnt % 8)] = dn_mosi;
      dn_cnt++;
    end
  end
  always @(negedge dn_sclk or posedge dn_clr) begin
    if (dn_clr) dn_miso = 1'b0;
    else dn_miso = (dn_cnt >= 32) ? FDATA[7 - (dn_cnt % 8)] : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_begin();
    dn_clr = 1'b1;
    @(negedge clk);
    dn_clr = 1'b0;
    for (int i = 0; i < 8; i++) rxb[i] = 8'h00;
    up_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      up_mosi = b[i];
      repeat (H - 1) @(negedge clk);
      r[i] = up_miso;
      up_sclk = 1'b1;
      repeat (H) @(negedge clk);
      up_sclk = 1'b0;
    end
  endtask

  task automatic spi_end();
    repeat (H) @(negedge clk);
    up_cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    logic [7:0] r;
    spi_begin();
    for (int k = 0; k < n; k++) begin
      spi_byte(txb[k], r);
      if (k < 8) rxb[k] = r;
    end
    spi_end();
  endtask

  task automatic set_half(input logic v);
    @(negedge clk); half_we = 1'b1; half_val = v;
    @(negedge clk); half_we = 1'b0;
  endtask

  task automatic set_pol(input logic [7:0] op, input logic [1:0] v);
    @(negedge clk); pol_we = 1'b1; pol_op = op; pol_val = v;
    @(negedge clk); pol_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); cap_clear = 1'b1;
    @(negedge clk); cap_clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_cmd(input logic [7:0] op);
    txb[0] = op; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h56;
    txb[4] = 8'h00; txb[5] = 8'h00; txb[6] = 8'h00;
  endtask

  // op, half, kind (0 local, 1 pass, 2 capture), first response byte
  typedef struct packed {
    logic [7:0] op;
    logic       half;
    logic [1:0] kind;
    logic [7:0] r1;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{op: 8'h03, half: 1'b0, kind: 2'd1, r1: 8'h00},
    '{op: 8'h03, half: 1'b1, kind: 2'd1, r1: 8'h00},
    '{op: 8'h05, half: 1'b0, kind: 2'd0, r1: 8'h00},
    '{op: 8'h9F, half: 1'b0, kind: 2'd0, r1: 8'hC2},
    '{op: 8'hAB, half: 1'b1, kind: 2'd0, r1: 8'h00},
    '{op: 8'h02, half: 1'b0, kind: 2'd2, r1: 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; up_cs_n = 1'b1; up_sclk = 1'b0; up_mosi = 1'b0;
    half_we = 1'b0; half_val = 1'b0; pol_we = 1'b0; pol_op = 8'h00; pol_val = 2'b00;
    cap_clear = 1'b0; cap_rd_idx = 8'h00; dn_clr = 1'b1;
    repeat (4) @(negedge clk);
    dn_clr = 1'b0;
    // R11 reset state
    chk("R11 dn_cs_n", 32'(dn_cs_n), 32'd1);
    chk("R11 dn_sclk", 32'(dn_sclk), 32'd0);
    chk("R11 up_miso", 32'(up_miso), 32'd0);
    chk("R11 cap_pending", 32'(cap_pending), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table-driven policies (R2, R3, R4, R6, R10)
    foreach (VEC[i]) begin
      set_half(VEC[i].half);
      load_cmd(VEC[i].op);
      xfer(6);
      case (VEC[i].kind)
        2'd1: begin
          chk("R3 relayed bits", 32'(dn_cnt), 32'd40);
          chk("R3 opcode relayed", 32'(dn_bytes[0]), 32'(VEC[i].op));
          chk("R4 half bit", 32'(dn_bytes[1]), 32'({VEC[i].half, 7'h12}));
          chk("R4 other addr", 32'(dn_bytes[2]), 32'h34);
          chk("R3 flash data back", 32'(rxb[5]), 32'(FDATA));
        end
        2'd0: begin
          chk("R1 local no flash", 32'(dn_cnt), 32'd0);
          chk("R2 local response", 32'(rxb[1]), 32'(VEC[i].r1));
        end
        default: begin
          chk("R6 capture no flash", 32'(dn_cnt), 32'd0);
          chk("R6 pending", 32'(cap_pending), 32'd1);
          chk("R6 cap_op", 32'(cap_op), 32'(VEC[i].op));
          chk("R6 cap_addr", 32'(cap_addr), 32'h123456);
          chk("R6 cap_len", 32'(cap_len), 32'd2);
          do_clear();
          chk("R6 cleared", 32'(cap_pending), 32'd0);
        end
      endcase
    end

    // R2 ID bytes repeat
    load_cmd(8'h9F);
    xfer(5);
    chk("R2 id byte1", 32'(rxb[2]), 32'h20);
    chk("R2 id byte2", 32'(rxb[3]), 32'h18);
    chk("R2 id wrap", 32'(rxb[4]), 32'hC2);

    // R9 busy, R8 rejection
    txb[0] = 8'h06;
    xfer(1);
    chk("R6 wren pending", 32'(cap_pending), 32'd1);
    load_cmd(8'h05);
    xfer(2);
    chk("R9 busy status", 32'(rxb[1]), 32'h01);
    txb[0] = 8'h02; txb[1] = 8'hAA; txb[2] = 8'hBB; txb[3] = 8'hCC; txb[4] = 8'h77;
    xfer(5);
    chk("R8 op kept", 32'(cap_op), 32'h06);
    chk("R8 len kept", 32'(cap_len), 32'd0);
    chk("R8 addr kept", 32'(cap_addr), 32'h123456);
    chk("R8 no flash", 32'(dn_cnt), 32'd0);
    do_clear();
    load_cmd(8'h05);
    xfer(2);
    chk("R9 idle status", 32'(rxb[1]), 32'h00);

    // R7 overflow of capture buffer
    txb[0] = 8'h02; txb[1] = 8'hAB; txb[2] = 8'hCD; txb[3] = 8'hEF;
    for (int i = 0; i < 260; i++) txb[4 + i] = 8'(i) ^ 8'h5A;
    xfer(264);
    chk("R7 len saturates", 32'(cap_len), 32'd256);
    chk("R6 addr long", 32'(cap_addr), 32'hABCDEF);
    @(negedge clk); cap_rd_idx = 8'd0; #1;
    chk("R6 first data", 32'(cap_rd_data), 32'h5A);
    @(negedge clk); cap_rd_idx = 8'd255; #1;
    chk("R7 last stored", 32'(cap_rd_data), 32'hA5);
    do_clear();

    // R5 half write mid-transaction, R1 select timing
    set_half(1'b0);
    load_cmd(8'h03);
    spi_begin();
    chk("R1 no select before opcode", 32'(dn_cs_n), 32'd1);
    spi_byte(txb[0], r);
    @(negedge clk);
    chk("R1 select after pass opcode", 32'(dn_cs_n), 32'd0);
    set_half(1'b1);
    for (int k = 1; k < 5; k++) spi_byte(txb[k], r);
    spi_end();
    chk("R1 deselect at end", 32'(dn_cs_n), 32'd1);
    chk("R5 old half kept", 32'(dn_bytes[1]), 32'h12);
    xfer(5);
    chk("R5 new half next txn", 32'(dn_bytes[1]), 32'h92);

    // R10 policy reprogramming
    set_pol(8'h05, 2'b01);
    load_cmd(8'h05);
    xfer(5);
    chk("R10 status now passes", 32'(dn_bytes[0]), 32'h05);
    set_pol(8'h03, 2'b10);
    load_cmd(8'h03);
    xfer(5);
    chk("R10 read now captured", 32'(cap_pending), 32'd1);
    chk("R10 captured no flash", 32'(dn_cnt), 32'd0);
    do_clear();
    set_pol(8'h9F, 2'b11);
    load_cmd(8'h9F);
    xfer(2);
    chk("R10 code 3 is local", 32'(rxb[1]), 32'hC2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule